// File: doc/BRIEF.md
# Programmable Clock Divider with Stop Control

This block derives one output clock from one of several parent clocks. Every parent is presented as a tick strobe in the block's own clock domain, and the block counts the ticks of the chosen parent. A 6-bit divisor field sets a ratio from 1 to 64. A stop bit gates the output, and a source-select field chooses the parent.

Software programs the block through a single 32-bit control register. A write strobe loads the whole register. A read strobe captures its contents onto the read-data port. Changes to the ratio, the parent or the stop state are held until the current output period has finished, so the output never shows a shortened pulse. A stop request is not honoured when the divisor field written with it is zero.

Top module: `clkdiv_stop`

## Requirements
- R1: A divisor field (register bits [5:0]) value of N divides the selected parent by N+1, so the output period is N+1 parent ticks, from 1 up to 64.
- R2: For a ratio R of 2 or more, the output is high for floor(R/2) parent ticks and low for the rest of each period. Odd ratios therefore have the shorter high phase.
- R3: With ratio 1 and the clock running, the output equals the selected parent tick strobe.
- R4: Register bit 8 is the stop bit. Writing 1 (with a non-zero divisor field) holds the output low from the next period boundary. Writing 0 restarts the output.
- R5: A write that sets bit 8 while its divisor field is zero has no effect on the run state, so a running clock keeps running.
- R6: A stop write whose divisor field is all ones (0x13F) is honoured.
- R7: The source-select field sits at bits [SEL_LSB+SEL_W-1:SEL_LSB] (default bits [13:12]) and selects the parent by index. An index of NUM_SRC or more leaves the current parent in use.
- R8: A new ratio, parent or stop state takes effect only when the current output period ends.
- R9: After reset the register reads 0x0000013F (divisor all ones, stopped, source 0) and the output is low.
- R10: A read strobe returns, one cycle later, the register exactly as last written, ignored stop requests included. A read-modify-write of the divisor keeps the stop and select bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all parent ticks are synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Register contents captured on the previous read strobe |
| src_tick | input | NUM_SRC | One tick strobe per parent clock |
| div_clk_out | output | 1 | Divided, gated output clock |

## Verification
The bench measures high time and rising-edge count over whole periods, for even, odd, unity and maximum ratios and for each parent. A wrong duty formula or an off-by-one ratio therefore shows up as a count mismatch. It retunes the divider in the middle of a long high phase. A design that applies changes at once cuts that phase short of 32 cycles instead of finishing it. A stop written with a zero divisor must leave the output toggling, and a design that honours it goes silent. An out-of-range select must keep the old parent, so a design that drops to another parent or to none changes the measured period.

// File: rtl/clkdiv_stop_pkg.sv
package clkdiv_stop_pkg;

    localparam int CTRL_W    = 32;
    localparam int DIV_W     = 6;
    localparam int STOP_BIT  = 8;
    localparam int SEL_MAX_W = 4;

    typedef logic [DIV_W-1:0]     div_t;
    typedef logic [SEL_MAX_W-1:0] sel_t;

    typedef struct packed {
        logic run;
        sel_t sel;
        div_t div_n;
    } cfg_t;

    function automatic logic [CTRL_W-1:0] ctrl_reset_value();
        logic [CTRL_W-1:0] v;
        v = '0;
        v[STOP_BIT]    = 1'b1;
        v[DIV_W-1:0]   = '1;
        return v;
    endfunction

    // Number of parent ticks the output stays high for a field value n.
    function automatic logic [DIV_W:0] high_ticks(input div_t n);
        logic [DIV_W:0] ratio;
        ratio = {1'b0, n} + 1'b1;
        return ratio >> 1;
    endfunction

endpackage

// File: rtl/clkdiv_stop_ctrl.sv
module clkdiv_stop_ctrl
    import clkdiv_stop_pkg::*;
#(
    parameter int SEL_LSB = 12,
    parameter int SEL_W   = 2,
    parameter int NUM_SRC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [CTRL_W-1:0] rd_data,
    output cfg_t              req,
    output logic              req_sel_ok
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [CTRL_W-1:0] rd_q;
    logic              stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_reset_value();
            stop_q <= 1'b1;
            rd_q   <= '0;
        end else begin
            if (wr_en) begin
                ctrl_q <= wr_data;
                if (!wr_data[STOP_BIT]) begin
                    stop_q <= 1'b0;
                end else if (wr_data[DIV_W-1:0] != '0) begin
                    stop_q <= 1'b1;
                end
            end
            if (rd_en) begin
                rd_q <= ctrl_q;
            end
        end
    end

    always_comb begin
        req.div_n  = ctrl_q[DIV_W-1:0];
        req.sel    = SEL_MAX_W'(ctrl_q[SEL_LSB +: SEL_W]);
        req.run    = !stop_q;
        req_sel_ok = (int'(req.sel) < NUM_SRC);
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/clkdiv_stop_mux.sv
module clkdiv_stop_mux
    import clkdiv_stop_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] tick_in,
    input  sel_t               sel,
    output logic               tick_out
);

    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = tick_in[i] & (sel == SEL_MAX_W'(i));
    end

    assign tick_out = |hit;

endmodule

// File: rtl/clkdiv_stop_core.sv
module clkdiv_stop_core
    import clkdiv_stop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t req,
    input  logic req_sel_ok,
    input  logic tick,
    output cfg_t act,
    output div_t cnt,
    output logic clk_out
);

    cfg_t act_q;
    div_t cnt_q;
    logic wrap;

    assign wrap = act_q.run && tick && (cnt_q == act_q.div_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q.run   <= 1'b0;
            act_q.sel   <= '0;
            act_q.div_n <= '1;
            cnt_q       <= '0;
        end else if (!act_q.run || wrap) begin
            act_q.run   <= req.run;
            act_q.div_n <= req.div_n;
            if (req_sel_ok) begin
                act_q.sel <= req.sel;
            end
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (!act_q.run) begin
            clk_out = 1'b0;
        end else if (act_q.div_n == '0) begin
            clk_out = tick;
        end else begin
            clk_out = ({1'b0, cnt_q} < high_ticks(act_q.div_n));
        end
    end

    assign act = act_q;
    assign cnt = cnt_q;

endmodule

// File: rtl/clkdiv_stop.sv
module clkdiv_stop
    import clkdiv_stop_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int SEL_LSB = 12,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    input  logic               rd_en,
    output logic [31:0]        rd_data,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               div_clk_out
);

    cfg_t req_cfg;
    cfg_t act_cfg;
    div_t cnt_q;
    logic req_sel_ok;
    logic tick_sel;
    logic run_req;

    clkdiv_stop_ctrl #(
        .SEL_LSB (SEL_LSB),
        .SEL_W   (SEL_W),
        .NUM_SRC (NUM_SRC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .req        (req_cfg),
        .req_sel_ok (req_sel_ok)
    );

    clkdiv_stop_mux #(
        .NUM_SRC (NUM_SRC)
    ) u_mux (
        .tick_in  (src_tick),
        .sel      (act_cfg.sel),
        .tick_out (tick_sel)
    );

    clkdiv_stop_core u_core (
        .clk        (clk),
        .rst        (rst),
        .req        (req_cfg),
        .req_sel_ok (req_sel_ok),
        .tick       (tick_sel),
        .act        (act_cfg),
        .cnt        (cnt_q),
        .clk_out    (div_clk_out)
    );

    assign run_req = req_cfg.run;

endmodule

// File: rtl/clkdiv_stop_chk.sv
module clkdiv_stop_chk
    import clkdiv_stop_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        tick_sel,
    input logic        run_req,
    input cfg_t        act_cfg,
    input div_t        cnt_q
);

    // R5
    zero_div_stop_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[STOP_BIT] && (wr_data[DIV_W-1:0] == '0))
        |=> (run_req == $past(run_req)));

    // R7
    active_sel_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(act_cfg.sel) < NUM_SRC);

    // R8
    ratio_change_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(act_cfg.run) && (act_cfg.div_n != $past(act_cfg.div_n)))
        |-> ($past(tick_sel) && ($past(cnt_q) == $past(act_cfg.div_n))));

    // R8
    stop_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(act_cfg.run)
        |-> ($past(tick_sel) && ($past(cnt_q) == $past(act_cfg.div_n))));

endmodule

bind clkdiv_stop clkdiv_stop_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .tick_sel (tick_sel),
    .run_req  (run_req),
    .act_cfg  (act_cfg),
    .cnt_q    (cnt_q)
);

// File: tb/tb_clkdiv_stop.sv
module tb_clkdiv_stop;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [2:0]  src_tick = 3'b001;
    logic        div_clk_out;

    int n_chk = 0;
    int n_fail = 0;
    int ph = 0;
    bit done = 0;

    clkdiv_stop dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .src_tick    (src_tick),
        .div_clk_out (div_clk_out)
    );

    always #5 clk = ~clk;

    // parent 0 ticks every cycle, parent 1 every 2nd, parent 2 every 3rd
    always @(negedge clk) begin
        ph = ph + 1;
        src_tick[0] = 1'b1;
        src_tick[1] = (ph % 2 == 0);
        src_tick[2] = (ph % 3 == 0);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic samp(output logic s);
        @(posedge clk);
        #2;
        s = div_clk_out;
    endtask

    task automatic check_wave(input string req, input int per, input int high);
        logic s;
        logic prev;
        int h = 0;
        int r = 0;
        repeat (200) @(posedge clk);
        samp(prev);
        for (int i = 0; i < 3 * per; i++) begin
            samp(s);
            if (s && !prev) r++;
            if (s) h++;
            prev = s;
        end
        chk({req, " high cycles"}, h, 3 * high);
        chk({req, " rising edges"}, r, 3);
    endtask

    task automatic count_high(input string req, input int win, input int exp);
        logic s;
        int h = 0;
        repeat (200) @(posedge clk);
        for (int i = 0; i < win; i++) begin
            samp(s);
            if (s) h++;
        end
        chk(req, h, exp);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(v);
        chk("R9 reset register", int'(v), 32'h13F);
        count_high("R9 output low after reset", 50, 0);
    endtask

    task automatic t_ratios;
        reg_write(32'h001);
        check_wave("R1 R2 ratio 2", 2, 1);
        reg_write(32'h004);
        check_wave("R2 odd ratio 5", 5, 2);
        reg_write(32'h03F);
        check_wave("R1 ratio 64", 64, 32);
    endtask

    task automatic t_boundary;
        logic s;
        logic prev;
        int h = 0;
        int l = 0;
        int h2 = 0;
        bit wrote = 0;
        samp(prev);
        samp(s);
        while (!(s && !prev)) begin
            prev = s;
            samp(s);
        end
        while (s) begin
            h++;
            @(negedge clk);
            if (h == 3 && !wrote) begin
                wr_en = 1'b1;
                wr_data = 32'h001;
                wrote = 1;
            end else begin
                wr_en = 1'b0;
            end
            samp(s);
        end
        while (!s) begin
            l++;
            samp(s);
        end
        while (s) begin
            h2++;
            samp(s);
        end
        chk("R8 old high phase completes", h, 32);
        chk("R8 old low phase completes", l, 32);
        chk("R8 new ratio high phase", h2, 1);
    endtask

    task automatic t_sources;
        reg_write(32'h1000);
        check_wave("R3 ratio 1 parent 1", 2, 1);
        reg_write(32'h2002);
        check_wave("R7 parent 2 ratio 3", 9, 3);
        reg_write(32'h3001);
        check_wave("R7 out-of-range select keeps parent 2", 6, 3);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        reg_write(32'h000);
        count_high("R3 ratio 1 parent 0 constant high", 50, 50);
        reg_write(32'h100);
        count_high("R5 stop with zero divisor ignored", 50, 50);
        reg_read(v);
        chk("R10 ignored write reads back", int'(v), 32'h100);
        reg_write(32'h13F);
        count_high("R4 R6 stop with all-ones divisor", 100, 0);
        reg_write(32'h004);
        check_wave("R4 restart ratio 5", 5, 2);
    endtask

    task automatic t_rmw;
        logic [31:0] v;
        reg_write(32'h1004);
        check_wave("R7 parent 1 ratio 5", 10, 4);
        reg_read(v);
        reg_write((v & ~32'h3F) | 32'h001);
        reg_read(v);
        chk("R10 read-modify-write readback", int'(v), 32'h1001);
        check_wave("R10 read-modify-write keeps parent", 4, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ratios();
        t_boundary();
        t_sources();
        t_stop();
        t_rmw();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule